// File: doc/BRIEF.md
# Reset Request and Cause Recorder

This block lets software ask for a full system reset and keeps a record of why the device was last reset. Software writes a 4-bit multi-bit boolean into the request field. While that field holds the true encoding, the block raises a request toward the external power controller. When the power controller reports that the reset sequence has finished, the request field returns to its false encoding by itself.

The cause record is an 8-bit sticky register. Bit 0 means power-on. Bit 1 means low-power exit. Bit 2 means software request. Bits 7:3 name five hardware requesters: bit 3 is the system reset controller, bit 4 the watchdog, bit 5 a main-power glitch, bit 6 an alert escalation, and bit 7 a non-debug reset from the debug module. Events seen before completion are held privately. They appear in the record only when the completion pulse arrives, and they join any cause bits already recorded. Software clears bits by writing ones.

The block's own reset input stands for power-on. It is the only thing that wipes the record, and afterwards the record shows only the power-on bit. Registers are reached through a single-cycle write port and a combinational read port. Word index 0 is the request field and word index 1 is the cause record.

Top module: `rst_cause_rec`

## Requirements
- R1: After `rst_n` is released, the request word reads 0x9, the cause word reads 0x01 and `sys_rst_req_o` is low.
- R2: `sys_rst_req_o` is high exactly while the request field holds 0x6. Any other value, such as 0x0, 0x7, 0x9 or 0xF, gives no request. The stored value reads back unchanged.
- R3: In the cycle after a `rst_done_i` pulse, the request field reads 0x9 and `sys_rst_req_o` is low. This return to 0x9 overrides a request write made in the same cycle.
- R4: If a software request was active at any point since the previous completion, bit 2 of the cause word is set on the next `rst_done_i`.
- R5: A pulse on `hw_req_i[k]` sets cause bit 3+k on the next `rst_done_i`.
- R6: A pulse on `lp_exit_i` sets cause bit 1 on the next `rst_done_i`.
- R7: Committing new causes never clears bits that are already recorded.
- R8: Writing to the cause word clears every bit written as 1 and leaves every bit written as 0 unchanged. If a clear and a commit hit the same bit in the same cycle, the bit ends up set.
- R9: Request word bits 31:4 and cause word bits 31:8 always read zero. Writes to those bits have no effect. Any unmapped word index reads zero.
- R10: Pending events do not change the cause word until `rst_done_i` arrives.
- R11: Asserting `rst_n` discards any pending events and leaves the cause word at 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Word index of the write |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Word index of the read |
| rd_data_o | output | DATA_W | Combinational read data |
| sys_rst_req_o | output | 1 | System reset request to the power controller |
| lp_exit_i | input | 1 | Pulse: reset caused by low-power exit |
| hw_req_i | input | NUM_HW | Pulses from the hardware reset requesters |
| rst_done_i | input | 1 | Pulse: the system reset has completed |

## Verification
The bound checker watches every cycle for the following:
- the request output rises only after a write of the true encoding;
- the request output drops after each completion;
- the record stays frozen between completions unless software clears it;
- a commit never loses earlier bits;
- hardware and software causes land in their mapped positions.

Some behaviour only the directed scenarios can show:
- the full set of encodings that do not request;
- that write-0 bits leave the record intact;
- that a set wins over a clear in the same cycle;
- that a completion overrides a same-cycle write;
- that power-on discards pending events.

// File: rtl/rsn_pkg.sv
// Shared constants for the reset request and cause recorder.
// Assumes a 4-bit multi-bit boolean request field.
package rsn_pkg;
    localparam int         REQ_W     = 4;
    localparam logic [3:0] MUBI_TRUE = 4'h6;
    localparam logic [3:0] MUBI_FALSE = 4'h9;
    localparam int         FIXED_CAUSES = 3;   // power-on, low-power exit, software
    localparam int         BIT_POR   = 0;
    localparam int         BIT_LPX   = 1;
    localparam int         BIT_SWR   = 2;
    localparam int         BIT_HW0   = 3;
    localparam int         ADR_REQ   = 0;
    localparam int         ADR_CAUSE = 1;
endpackage

// File: rtl/rsn_req_reg.sv
// Software reset request field.
// Stores any 4-bit value and flags a request only while it holds the true encoding.
// A completion returns the field to the false encoding, overriding a same-cycle write.
module rsn_req_reg
    import rsn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [REQ_W-1:0] wr_val,
    input  logic             done,
    output logic [REQ_W-1:0] req_q,
    output logic             req_active
);
    // Request field storage with hardware return on completion
    always_ff @(posedge clk) begin
        if (!rst_n)       req_q <= MUBI_FALSE;
        else if (done)    req_q <= MUBI_FALSE;
        else if (wr_fire) req_q <= wr_val;
    end

    // Only the exact true encoding counts as a request
    always_comb req_active = (req_q == MUBI_TRUE);
endmodule

// File: rtl/rsn_cause_log.sv
// Sticky reset cause record.
// Events are held as pending bits and committed on completion, ORed into the record.
// Bits clear on a write of 1. A commit wins over a same-cycle clear.
// Power-on reset leaves only bit 0 set.
module rsn_cause_log
    import rsn_pkg::*;
#(
    parameter int NUM_HW = 5,
    localparam int CW = FIXED_CAUSES + NUM_HW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_fire,
    input  logic [CW-1:0]     clr_mask,
    input  logic              sw_active,
    input  logic              lp_exit,
    input  logic [NUM_HW-1:0] hw_req,
    input  logic              done,
    output logic [CW-1:0]     cause_q
);
    logic [CW-1:0] ev;
    logic [CW-1:0] pend_q;

    // Gather this cycle's events in record bit order
    always_comb begin
        ev          = '0;
        ev[BIT_LPX] = lp_exit;
        ev[BIT_SWR] = sw_active;
        ev[BIT_HW0 +: NUM_HW] = hw_req;
    end

    for (genvar i = 0; i < CW; i++) begin : g_bit
        // Hold an event until the reset it caused has completed
        always_ff @(posedge clk) begin
            if (!rst_n)     pend_q[i] <= 1'b0;
            else if (done)  pend_q[i] <= 1'b0;
            else if (ev[i]) pend_q[i] <= 1'b1;
        end

        // Record bit: commit on completion, else clear on write of 1
        always_ff @(posedge clk) begin
            if (!rst_n)                          cause_q[i] <= (i == BIT_POR);
            else if (done && (pend_q[i] || ev[i])) cause_q[i] <= 1'b1;
            else if (clr_fire && clr_mask[i])    cause_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rst_cause_rec.sv
// Top of the reset request and cause recorder.
// Decodes the register port, forwards the software request and reads back both words.
// Word index 0 is the request field and word index 1 is the cause record.
module rst_cause_rec
    import rsn_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int NUM_HW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              sys_rst_req_o,
    input  logic              lp_exit_i,
    input  logic [NUM_HW-1:0] hw_req_i,
    input  logic              rst_done_i
);
    localparam int CW = FIXED_CAUSES + NUM_HW;

    logic             wr_req, wr_cause;
    logic [REQ_W-1:0] req_q;
    logic             req_active;
    logic [CW-1:0]    cause_q;
    logic             unused_hi;

    // Decode which word a write targets
    always_comb begin
        wr_req   = wr_en_i && (wr_addr_i == ADDR_W'(ADR_REQ));
        wr_cause = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CAUSE));
    end

    assign unused_hi = ^wr_data_i[DATA_W-1:CW];

    rsn_req_reg u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_req),
        .wr_val     (wr_data_i[REQ_W-1:0]),
        .done       (rst_done_i),
        .req_q      (req_q),
        .req_active (req_active)
    );

    rsn_cause_log #(.NUM_HW(NUM_HW)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_fire  (wr_cause),
        .clr_mask  (wr_data_i[CW-1:0]),
        .sw_active (req_active),
        .lp_exit   (lp_exit_i),
        .hw_req    (hw_req_i),
        .done      (rst_done_i),
        .cause_q   (cause_q)
    );

    assign sys_rst_req_o = req_active;

    // Read mux: zero-extended words, zero for unmapped indices
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(ADR_REQ))        rd_data_o[REQ_W-1:0] = req_q;
        else if (rd_addr_i == ADDR_W'(ADR_CAUSE)) rd_data_o[CW-1:0]    = cause_q;
    end
endmodule

// File: rtl/rst_cause_rec_chk.sv
// Property checker for rst_cause_rec, attached with bind. Observes only.
module rst_cause_rec_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int NUM_HW = 5,
    localparam int CW = 3 + NUM_HW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              sys_rst_req_o,
    input logic [NUM_HW-1:0] hw_req_i,
    input logic              rst_done_i,
    input logic [CW-1:0]     cause_q
);
    logic wr_c;
    assign wr_c = wr_en_i && (wr_addr_i == ADDR_W'(1));

    // R2: the request only rises after a write of the true encoding
    p_rise_on_true_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req_o) |-> $past(wr_en_i && wr_addr_i == ADDR_W'(0) && wr_data_i[3:0] == 4'h6));

    // R3: completion withdraws the request
    p_done_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done_i |=> !sys_rst_req_o);

    // R4: an active software request is recorded on completion
    p_sw_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done_i && sys_rst_req_o) |=> cause_q[2]);

    // R5: hardware requests land in their mapped bits
    p_hw_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done_i |=> ((cause_q[3 +: NUM_HW] & $past(hw_req_i)) == $past(hw_req_i)));

    // R7: a commit keeps earlier bits
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done_i && !wr_c) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    // R10: the record is frozen between completions unless cleared
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_done_i && !wr_c) |=> $stable(cause_q));

    // R9: upper read bits stay zero
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DATA_W-1:CW] == '0);
endmodule

bind rst_cause_rec rst_cause_rec_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_HW(NUM_HW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .rd_data_o     (rd_data_o),
    .sys_rst_req_o (sys_rst_req_o),
    .hw_req_i      (hw_req_i),
    .rst_done_i    (rst_done_i),
    .cause_q       (cause_q)
);

// File: tb/rst_cause_rec_test.sv
// Directed bench for rst_cause_rec: one task per scenario, each checking its own results.
module rst_cause_rec_test;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int NUM_HW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [ADDR_W-1:0] wr_addr_i = '0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic [ADDR_W-1:0] rd_addr_i = '0;
    logic [DATA_W-1:0] rd_data_o;
    logic              sys_rst_req_o;
    logic              lp_exit_i = 1'b0;
    logic [NUM_HW-1:0] hw_req_i = '0;
    logic              rst_done_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rst_cause_rec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_HW(NUM_HW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .sys_rst_req_o(sys_rst_req_o), .lp_exit_i(lp_exit_i), .hw_req_i(hw_req_i),
        .rst_done_i(rst_done_i)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input int adr, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = ADDR_W'(adr); wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input int adr, output logic [31:0] d);
        rd_addr_i = ADDR_W'(adr);
        #1 d = rd_data_o;
    endtask

    task automatic done_pulse();
        @(negedge clk); rst_done_i = 1'b1;
        @(negedge clk); rst_done_i = 1'b0;
    endtask

    task automatic hw_pulse(input int k);
        @(negedge clk); hw_req_i[k] = 1'b1;
        @(negedge clk); hw_req_i = '0;
    endtask

    task automatic apply_por();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(0, v); chk("R1 req word", v, 32'h9);
        rd(1, v); chk("R1 cause word", v, 32'h01);
        chk("R1 request out", 32'(sys_rst_req_o), 32'h0);
    endtask

    task automatic t_encodings();
        logic [31:0] v;
        logic [3:0] codes [4] = '{4'h0, 4'h7, 4'hF, 4'h9};
        foreach (codes[i]) begin
            wr(0, 32'(codes[i]));
            chk("R2 non-true gives no request", 32'(sys_rst_req_o), 32'h0);
            rd(0, v); chk("R2 readback", v, 32'(codes[i]));
        end
        wr(0, 32'h6);
        chk("R2 true raises request", 32'(sys_rst_req_o), 32'h1);
        rd(1, v); chk("R10 cause unchanged before completion", v, 32'h01);
    endtask

    task automatic t_sw_complete();
        logic [31:0] v;
        done_pulse();
        rd(0, v); chk("R3 field returns to false", v, 32'h9);
        chk("R3 request dropped", 32'(sys_rst_req_o), 32'h0);
        rd(1, v); chk("R4 R7 sw cause added, por kept", v, 32'h05);
    endtask

    task automatic t_accumulate();
        logic [31:0] v;
        hw_pulse(1);
        rd(1, v); chk("R10 pending watchdog hidden", v, 32'h05);
        done_pulse();
        rd(1, v); chk("R5 R7 watchdog bit 4 joins record", v, 32'h15);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(1, 32'h04);
        rd(1, v); chk("R8 write 1 clears one bit", v, 32'h11);
        wr(1, 32'h00);
        rd(1, v); chk("R8 write 0 keeps bits", v, 32'h11);
        wr(1, 32'hFF);
        rd(1, v); chk("R8 clear all", v, 32'h00);
    endtask

    task automatic t_hw_map();
        logic [31:0] v;
        for (int k = 0; k < NUM_HW; k++) begin
            hw_pulse(k);
            done_pulse();
            rd(1, v); chk("R5 hardware bit mapping", v, 32'(1) << (3 + k));
            wr(1, 32'hFF);
        end
    endtask

    task automatic t_lp_exit();
        logic [31:0] v;
        @(negedge clk); lp_exit_i = 1'b1;
        @(negedge clk); lp_exit_i = 1'b0;
        done_pulse();
        rd(1, v); chk("R6 low-power exit bit 1", v, 32'h02);
        wr(1, 32'hFF);
    endtask

    task automatic t_collisions();
        logic [31:0] v;
        // commit of bit 7 together with a clear-all write
        @(negedge clk);
        hw_req_i[4] = 1'b1; rst_done_i = 1'b1;
        wr_en_i = 1'b1; wr_addr_i = ADDR_W'(1); wr_data_i = 32'hFF;
        @(negedge clk);
        hw_req_i = '0; rst_done_i = 1'b0; wr_en_i = 1'b0;
        rd(1, v); chk("R8 set wins over same-cycle clear", v, 32'h80);
        // request write together with completion
        @(negedge clk);
        rst_done_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = ADDR_W'(0); wr_data_i = 32'h6;
        @(negedge clk);
        rst_done_i = 1'b0; wr_en_i = 1'b0;
        rd(0, v); chk("R3 completion overrides write", v, 32'h9);
        chk("R3 no request after collision", 32'(sys_rst_req_o), 32'h0);
        wr(1, 32'hFF);
    endtask

    task automatic t_upper_bits();
        logic [31:0] v;
        wr(0, 32'hFFFF_FFF0);
        rd(0, v); chk("R9 request upper bits zero", v, 32'h0);
        wr(0, 32'h9);
        hw_pulse(0); done_pulse();
        wr(1, 32'hFFFF_FF00);
        rd(1, v); chk("R9 upper cause writes ignored", v, 32'h08);
        rd(2, v); chk("R9 unmapped index reads zero", v, 32'h0);
    endtask

    task automatic t_por();
        logic [31:0] v;
        hw_pulse(3);
        wr(0, 32'h6);
        apply_por();
        rd(1, v); chk("R11 power-on leaves only bit 0", v, 32'h01);
        rd(0, v); chk("R11 request field reset", v, 32'h9);
        done_pulse();
        rd(1, v); chk("R11 pending events discarded", v, 32'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_encodings();
        t_sw_complete();
        t_accumulate();
        t_w1c();
        t_hw_map();
        t_lp_exit();
        t_collisions();
        t_upper_bits();
        t_por();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule